// File: doc/BRIEF.md
# SPI FPGA Configuration Sequencer

This block is an SPI master that brings up a target FPGA through its slave SPI configuration port without software involvement. After a start pulse it identifies the device, checks the identity against two accepted values, reads status once, and then prepares the configuration memory with three short commands. It polls status until the memory reports cleared, or gives up after a bounded number of polls. It then streams the bitstream in a single chip-select frame behind a write-increment header, turns writing off, and reads status one last time to see whether the device came up.

The bitstream arrives as a byte stream with a valid/ready handshake and a last flag. A source that has nothing to load presents a single marker beat instead, and the sequence is refused before any SPI activity. The SPI clock is derived directly from the system clock: one SCLK period spans two system cycles, bytes go out MSB first in mode 0, and chip select stays high for at least one SCLK period between frames. Poll spacing and the poll limit are parameters in system cycles and polls, so a simulation can use short values.

Top module: `cfg_spi_loader`

## Requirements
- R1: While reset is active, and after it, until start: `spi_cs_n` is 1, `spi_sclk` is 0, `cfg_done` and `cfg_err` are 0, and `bs_ready` is 0.
- R2: SPI is mode 0, MSB first: `spi_sclk` is high only while `spi_cs_n` is low, `spi_mosi` does not change while `spi_sclk` is high, and `spi_cs_n` stays high for at least two system cycles between frames.
- R3: If the first stream beat after start has `bs_valid`, `bs_last` and `bs_nodata` set, it is consumed, no SPI frame is sent, and the sequence ends with `cfg_err`=1 and `cfg_code`=0 (empty).
- R4: The first frame is 8 bytes: 0x07, three 0x00 bytes, then four bytes read back. The 32-bit ID takes the fifth byte as bits 7:0 through the eighth byte as bits 31:24. Only 0xC2088080 and 0xC2048080 are accepted. Any other ID ends the sequence after that frame with `cfg_code`=1 (unsupported).
- R5: After a good ID, the block sends an 8-byte status read (0x09 plus three 0x00 bytes, same reply layout). It then sends three separate 4-byte frames, in this order: 0x71, 0x4A, 0x70. Each is followed by three 0x00 bytes.
- R6: After the 0x70 frame, status reads repeat until a reply equals exactly 0x00010000. Between the end of one poll and the start of the next, chip select stays high for at least `POLL_WAIT_CYC` system cycles.
- R7: If `POLL_LIMIT` polls all fail to match, the sequence ends with `cfg_code`=2 (timeout) and no further frame.
- R8: The load frame is one chip-select frame: 0x41, 0xFF, 0xFF, 0xFF, every stream byte in order up to the beat with `bs_last`, then four 0x00 bytes. Stream stalls (`bs_valid` low) only pause it. `bs_ready` is high only together with `bs_valid`.
- R9: After the load frame, the block sends a 4-byte 0x4F frame (three 0x00 bytes after the opcode), then one 8-byte status read. The run succeeds (`cfg_err`=0) if status bit 14 (mask 0x00004000) is set. Otherwise it ends with `cfg_code`=3 (not done).
- R10: On completion `cfg_done` goes to 1 with `spi_cs_n` high. `cfg_done`, `cfg_err` and `cfg_code` hold until the next start, which clears `cfg_done` and `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a configuration run when idle or finished |
| bs_data | input | 8 | Bitstream byte |
| bs_valid | input | 1 | Stream beat present |
| bs_last | input | 1 | Beat is the final one of the stream |
| bs_nodata | input | 1 | Beat is the empty-stream marker |
| bs_ready | output | 1 | Beat accepted this cycle |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | SPI data to the target |
| spi_miso | input | 1 | SPI data from the target |
| spi_cs_n | output | 1 | Chip select, active low |
| cfg_done | output | 1 | Sequence finished |
| cfg_err | output | 1 | Sequence finished with an error |
| cfg_code | output | 2 | Error cause: 0 empty, 1 unsupported, 2 timeout, 3 not done |

## Verification
The bench models the target's slave port. During polling it answers with a status that has the cleared bit set plus one extra bit, so a design that tests only one bit instead of the whole word would start loading too early. It also feeds an ID that differs from a good one in a single low bit, which catches a partial compare or a wrong byte order. The poll limit is driven all the way out, and a design with an off-by-one in its poll count would send one poll too many or too few. The final status holds every bit except DONE, so a design that checks any other bit would report success. A stalling stream and a one-byte stream test whether the header, data and trailer stay in one frame with nothing dropped or repeated.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;

  typedef enum logic [1:0] {
    EC_EMPTY   = 2'd0,
    EC_BADID   = 2'd1,
    EC_TIMEOUT = 2'd2,
    EC_NODONE  = 2'd3
  } err_code_e;

  typedef enum logic [3:0] {
    SP_ID, SP_STAT, SP_REFRESH, SP_WREN, SP_CLEAR,
    SP_POLL, SP_STREAM, SP_WRDIS, SP_FINAL
  } step_e;

  typedef enum logic [2:0] {
    FS_IDLE, FS_PEEK, FS_GAP, FS_LOAD, FS_SHIFT, FS_EVAL, FS_WAIT, FS_END
  } fsm_e;

  localparam logic [31:0] DEV_ID_A     = 32'hC208_8080;
  localparam logic [31:0] DEV_ID_B     = 32'hC204_8080;
  localparam logic [31:0] STAT_CLEARED = 32'h0001_0000;
  localparam logic [31:0] STAT_DONE    = 32'h0000_4000;

  function automatic logic [7:0] step_opcode(step_e s);
    case (s)
      SP_ID:      return 8'h07;
      SP_REFRESH: return 8'h71;
      SP_WREN:    return 8'h4A;
      SP_CLEAR:   return 8'h70;
      SP_STREAM:  return 8'h41;
      SP_WRDIS:   return 8'h4F;
      default:    return 8'h09;
    endcase
  endfunction

  function automatic logic step_is_cmd(step_e s);
    return (s == SP_REFRESH) || (s == SP_WREN) || (s == SP_CLEAR) || (s == SP_WRDIS);
  endfunction

endpackage

// File: rtl/cfg_spi_rst_sync.sv
module cfg_spi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_spi_shifter.sv
// One byte per call, mode 0: MISO is sampled on the rising SCLK edge,
// the next MOSI bit is presented on the falling edge.
module cfg_spi_shifter #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [BW-1:0] tx,
  input  logic          miso,
  output logic          sclk,
  output logic          mosi,
  output logic [BW-1:0] rx,
  output logic          fin
);
  localparam int CW = $clog2(BW);

  logic [BW-1:0] sh_q, sh_d, rx_q, rx_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d, ph_q, ph_d, sclk_q, sclk_d, fin_q, fin_d;

  always_comb begin
    sh_d = sh_q; rx_d = rx_q; cnt_d = cnt_q;
    act_d = act_q; ph_d = ph_q; sclk_d = sclk_q; fin_d = 1'b0;
    if (go && !act_q) begin
      sh_d = tx; cnt_d = '0; act_d = 1'b1; ph_d = 1'b0; sclk_d = 1'b0;
    end else if (act_q) begin
      if (!ph_q) begin
        sclk_d = 1'b1;
        rx_d   = {rx_q[BW-2:0], miso};
        ph_d   = 1'b1;
      end else begin
        sclk_d = 1'b0;
        sh_d   = {sh_q[BW-2:0], 1'b0};
        ph_d   = 1'b0;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == CW'(BW-1)) begin
          act_d = 1'b0;
          fin_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; rx_q <= '0; cnt_q <= '0;
      act_q <= 1'b0; ph_q <= 1'b0; sclk_q <= 1'b0; fin_q <= 1'b0;
    end else begin
      sh_q <= sh_d; rx_q <= rx_d; cnt_q <= cnt_d;
      act_q <= act_d; ph_q <= ph_d; sclk_q <= sclk_d; fin_q <= fin_d;
    end
  end

  assign sclk = sclk_q;
  assign mosi = sh_q[BW-1];
  assign rx   = rx_q;
  assign fin  = fin_q;
endmodule

// File: rtl/cfg_spi_tally.sv
// Poll spacing timer and poll budget.
module cfg_spi_tally #(
  parameter int unsigned WAIT_CYC = 2_000_000,
  parameter int unsigned LIMIT    = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  input  logic wait_start,
  output logic wait_over,
  output logic last_poll
);
  localparam int TW = $clog2(WAIT_CYC + 1);
  localparam int PW = $clog2(LIMIT + 1);

  logic [TW-1:0] tmr_q, tmr_d;
  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    tmr_d = tmr_q;
    cnt_d = cnt_q;
    if (wait_start)         tmr_d = TW'(WAIT_CYC);
    else if (tmr_q != '0)   tmr_d = tmr_q - 1'b1;
    if (clr)                cnt_d = '0;
    else if (bump)          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      cnt_q <= '0;
    end else begin
      tmr_q <= tmr_d;
      cnt_q <= cnt_d;
    end
  end

  assign wait_over = (tmr_q == '0);
  assign last_poll = (cnt_q == PW'(LIMIT - 1));
endmodule

// File: rtl/cfg_spi_loader.sv
module cfg_spi_loader
  import cfg_spi_pkg::*;
#(
  parameter int unsigned POLL_WAIT_CYC = 2_000_000,
  parameter int unsigned POLL_LIMIT    = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] bs_data,
  input  logic       bs_valid,
  input  logic       bs_last,
  input  logic       bs_nodata,
  output logic       bs_ready,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       spi_cs_n,
  output logic       cfg_done,
  output logic       cfg_err,
  output logic [1:0] cfg_code
);
  logic rst_sync_n;
  fsm_e st_q, st_d;
  step_e step_q, step_d;
  logic [2:0]  idx_q, idx_d;
  logic [31:0] word_q, word_d;
  logic        strm_q, strm_d, tail_q, tail_d, gap_q, gap_d, cs_n_q, cs_n_d;
  logic        done_q, done_d, err_q, err_d;
  err_code_e   code_q, code_d;
  logic        go, fin, clr, bump, wstart, wait_over, last_poll, frame_end;
  logic [7:0]  tx, rx;

  cfg_spi_rst_sync #(.STAGES(2)) i_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  cfg_spi_shifter #(.BW(8)) i_shift (
    .clk(clk), .rst_n(rst_sync_n), .go(go), .tx(tx), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .rx(rx), .fin(fin)
  );

  cfg_spi_tally #(.WAIT_CYC(POLL_WAIT_CYC), .LIMIT(POLL_LIMIT)) i_tally (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr), .bump(bump), .wait_start(wstart),
    .wait_over(wait_over), .last_poll(last_poll)
  );

  always_comb begin
    if (idx_q == 3'd0)  tx = step_opcode(step_q);
    else if (!idx_q[2]) tx = (step_q == SP_STREAM) ? 8'hFF : 8'h00;
    else                tx = strm_q ? bs_data : 8'h00;
  end

  assign frame_end = step_is_cmd(step_q) ? (idx_q == 3'd3) : (!strm_q && idx_q == 3'd7);

  always_comb begin
    st_d = st_q; step_d = step_q; idx_d = idx_q; word_d = word_q;
    strm_d = strm_q; tail_d = tail_q; gap_d = gap_q; cs_n_d = cs_n_q;
    done_d = done_q; err_d = err_q; code_d = code_q;
    go = 1'b0; bs_ready = 1'b0; clr = 1'b0; bump = 1'b0; wstart = 1'b0;
    case (st_q)
      FS_IDLE, FS_END: if (start) begin
        st_d = FS_PEEK; done_d = 1'b0; err_d = 1'b0; clr = 1'b1;
      end
      FS_PEEK: if (bs_valid) begin
        if (bs_nodata) begin
          bs_ready = 1'b1; st_d = FS_END;
          done_d = 1'b1; err_d = 1'b1; code_d = EC_EMPTY;
        end else begin
          step_d = SP_ID; gap_d = 1'b0; st_d = FS_GAP;
        end
      end
      FS_GAP: if (gap_q) begin
        cs_n_d = 1'b0; idx_d = '0; strm_d = 1'b0; st_d = FS_LOAD;
      end else begin
        gap_d = 1'b1;
      end
      FS_LOAD: if (!strm_q || bs_valid) begin
        go = 1'b1; bs_ready = strm_q; tail_d = bs_last; st_d = FS_SHIFT;
      end
      FS_SHIFT: if (fin) begin
        if (idx_q[2]) word_d = {rx, word_q[31:8]};
        if (frame_end) begin
          cs_n_d = 1'b1; st_d = FS_EVAL;
        end else begin
          st_d = FS_LOAD;
          if (step_q == SP_STREAM && idx_q == 3'd3) begin
            strm_d = 1'b1; idx_d = idx_q + 1'b1;
          end else if (strm_q) begin
            strm_d = !tail_q;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      FS_EVAL: begin
        gap_d = 1'b0; st_d = FS_GAP;
        case (step_q)
          SP_ID:
            if (word_q == DEV_ID_A || word_q == DEV_ID_B) step_d = SP_STAT;
            else begin st_d = FS_END; done_d = 1'b1; err_d = 1'b1; code_d = EC_BADID; end
          SP_STAT:    step_d = SP_REFRESH;
          SP_REFRESH: step_d = SP_WREN;
          SP_WREN:    step_d = SP_CLEAR;
          SP_CLEAR:   step_d = SP_POLL;
          SP_POLL:
            if (word_q == STAT_CLEARED) step_d = SP_STREAM;
            else if (last_poll) begin
              st_d = FS_END; done_d = 1'b1; err_d = 1'b1; code_d = EC_TIMEOUT;
            end else begin
              bump = 1'b1; wstart = 1'b1; st_d = FS_WAIT;
            end
          SP_STREAM:  step_d = SP_WRDIS;
          SP_WRDIS:   step_d = SP_FINAL;
          default: begin
            st_d = FS_END; done_d = 1'b1;
            err_d  = ((word_q & STAT_DONE) == 32'h0);
            code_d = ((word_q & STAT_DONE) == 32'h0) ? EC_NODONE : EC_EMPTY;
          end
        endcase
      end
      FS_WAIT: if (wait_over) begin
        gap_d = 1'b0; st_d = FS_GAP;
      end
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q <= FS_IDLE; step_q <= SP_ID; idx_q <= '0; word_q <= '0;
      strm_q <= 1'b0; tail_q <= 1'b0; gap_q <= 1'b0; cs_n_q <= 1'b1;
      done_q <= 1'b0; err_q <= 1'b0; code_q <= EC_EMPTY;
    end else begin
      st_q <= st_d; step_q <= step_d; idx_q <= idx_d; word_q <= word_d;
      strm_q <= strm_d; tail_q <= tail_d; gap_q <= gap_d; cs_n_q <= cs_n_d;
      done_q <= done_d; err_q <= err_d; code_q <= code_d;
    end
  end

  assign spi_cs_n = cs_n_q;
  assign cfg_done = done_q;
  assign cfg_err  = err_q;
  assign cfg_code = code_q;
endmodule

// File: rtl/cfg_spi_loader_chk.sv
module cfg_spi_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic spi_cs_n,
  input logic bs_valid,
  input logic bs_ready,
  input logic cfg_done,
  input logic cfg_err
);
  a_r2_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> !spi_cs_n);

  a_r2_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));

  a_r2_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);

  a_r8_ready_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    bs_ready |-> bs_valid);

  a_r10_err_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> cfg_done);

  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> spi_cs_n);
endmodule

bind cfg_spi_loader cfg_spi_loader_chk i_chk (
  .clk(clk), .rst_n(rst_sync_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
  .spi_cs_n(spi_cs_n), .bs_valid(bs_valid), .bs_ready(bs_ready),
  .cfg_done(cfg_done), .cfg_err(cfg_err)
);

// File: tb/test_cfg_spi_loader.sv
`timescale 1ns/1ps
module test_cfg_spi_loader;
  localparam int WAITC = 20;
  localparam int LIM   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic start = 1'b0;
  logic [7:0] bs_data = 8'h00;
  logic bs_valid = 1'b0, bs_last = 1'b0, bs_nodata = 1'b0;
  logic bs_ready, spi_sclk, spi_mosi, spi_cs_n, cfg_done, cfg_err;
  logic spi_miso = 1'b0;
  logic [1:0] cfg_code;

  cfg_spi_loader #(.POLL_WAIT_CYC(WAITC), .POLL_LIMIT(LIM)) i_cfg_spi_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .bs_data(bs_data), .bs_valid(bs_valid),
    .bs_last(bs_last), .bs_nodata(bs_nodata), .bs_ready(bs_ready), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .cfg_done(cfg_done),
    .cfg_err(cfg_err), .cfg_code(cfg_code)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // target slave model
  logic [31:0] id_val, fin_val;
  int need, polls_ac, bitn, nby, nfr, s_len;
  bit clr_seen, wdis_seen;
  logic [7:0] sh;
  logic [7:0] fr_b [64];
  logic [7:0] s_b [64];
  int f_op [32], f_len [32], f_mid [32], f_fall [32], f_rise [32];
  logic pcs = 1'b1, psclk = 1'b0;

  function logic [31:0] slave_word();
    if (fr_b[0] == 8'h07) return id_val;
    if (fr_b[0] == 8'h09) begin
      if (wdis_seen) return fin_val;
      if (clr_seen)  return (polls_ac >= need) ? 32'h0001_0000 : 32'h0001_0100;
    end
    return 32'h0;
  endfunction

  function logic miso_bit(int n);
    logic [31:0] w;
    if (n < 32 || n >= 64) return 1'b0;
    w = slave_word();
    return w[((n / 8) - 4) * 8 + 7 - (n % 8)];
  endfunction

  always @(negedge clk) begin
    if (pcs && !spi_cs_n) begin
      bitn = 0; nby = 0;
      for (int i = 0; i < 4; i++) fr_b[i] = 8'h00;
      if (nfr < 32) f_fall[nfr] = cyc;
      spi_miso = miso_bit(0);
    end
    if (!spi_cs_n && !psclk && spi_sclk) begin
      sh = {sh[6:0], spi_mosi};
      bitn++;
      if (bitn % 8 == 0) begin
        if (nby < 64) fr_b[nby] = sh;
        nby++;
      end
    end
    if (!spi_cs_n && psclk && !spi_sclk) spi_miso = miso_bit(bitn);
    if (!pcs && spi_cs_n) begin
      if (nfr < 32) begin
        f_op[nfr] = fr_b[0]; f_len[nfr] = nby; f_rise[nfr] = cyc;
        f_mid[nfr] = fr_b[1] | fr_b[2] | fr_b[3];
      end
      if (fr_b[0] == 8'h70) clr_seen = 1;
      if (fr_b[0] == 8'h4F) wdis_seen = 1;
      if (fr_b[0] == 8'h09 && clr_seen && !wdis_seen) polls_ac++;
      if (fr_b[0] == 8'h41) begin
        s_len = nby;
        for (int i = 0; i < 64; i++) s_b[i] = fr_b[i];
      end
      nfr++;
    end
    pcs = spi_cs_n; psclk = spi_sclk;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // stimulus
  logic [7:0] tx_d [16];
  int tx_n;
  bit use_gaps, seq_over;

  task automatic feed(input bit empty);
    int i = 0;
    while (!seq_over && (i < tx_n || (empty && i == 0))) begin
      @(negedge clk);
      if (use_gaps && (i % 2 == 1)) begin
        bs_valid = 1'b0;
        repeat (3) @(negedge clk);
      end
      bs_valid = 1'b1; bs_data = tx_d[i];
      bs_last = empty || (i == tx_n - 1); bs_nodata = empty;
      #1;
      while (!bs_ready && !seq_over) begin @(negedge clk); #1; end
      if (!seq_over) @(posedge clk);
      i++;
    end
    @(negedge clk);
    bs_valid = 1'b0; bs_last = 1'b0; bs_nodata = 1'b0;
  endtask

  task automatic wait_end();
    int t = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!cfg_done && t < 20000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    seq_over = 1;
  endtask

  task automatic run_seq(input bit empty);
    nfr = 0; clr_seen = 0; wdis_seen = 0; polls_ac = 0; s_len = 0; seq_over = 0;
    fork
      feed(empty);
      wait_end();
    join
  endtask

  task automatic t_reset();
    chk(spi_cs_n == 1'b1, "R1 cs_n idle", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R1 sclk idle", spi_sclk, 0);
    chk(cfg_done == 1'b0 && cfg_err == 1'b0, "R1 done/err clear", {cfg_done, cfg_err}, 0);
    chk(bs_ready == 1'b0, "R1 ready low", bs_ready, 0);
  endtask

  task automatic t_empty();
    tx_n = 0; use_gaps = 0; id_val = 32'hC208_8080;
    run_seq(1);
    chk(cfg_done && cfg_err, "R3 empty ends with error", {cfg_done, cfg_err}, 3);
    chk(cfg_code == 2'd0, "R3 empty code", cfg_code, 0);
    chk(nfr == 0, "R3 no SPI frame", nfr, 0);
  endtask

  task automatic t_badid();
    tx_n = 1; tx_d[0] = 8'h11; use_gaps = 0; id_val = 32'hC208_8081;
    run_seq(0);
    chk(cfg_err && cfg_code == 2'd1, "R4 unsupported code", cfg_code, 1);
    chk(nfr == 1, "R4 only ID frame", nfr, 1);
    chk(f_op[0] == 8'h07 && f_len[0] == 8 && f_mid[0] == 0, "R4 ID frame shape", f_op[0], 8'h07);
  endtask

  task automatic t_good();
    int eop [11] = '{8'h07, 8'h09, 8'h71, 8'h4A, 8'h70, 8'h09, 8'h09, 8'h09, 8'h41, 8'h4F, 8'h09};
    int eln [11] = '{8, 8, 4, 4, 4, 8, 8, 8, 13, 4, 8};
    logic [7:0] es [13] = '{8'h41, 8'hFF, 8'hFF, 8'hFF, 8'hA5, 8'h3C, 8'h00, 8'hFF, 8'h81,
                            8'h00, 8'h00, 8'h00, 8'h00};
    bit ok;
    tx_n = 5; tx_d[0] = 8'hA5; tx_d[1] = 8'h3C; tx_d[2] = 8'h00; tx_d[3] = 8'hFF; tx_d[4] = 8'h81;
    use_gaps = 1; id_val = 32'hC208_8080; need = 2; fin_val = 32'h0000_4000;
    run_seq(0);
    chk(cfg_done && !cfg_err, "R9 success", {cfg_done, cfg_err}, 2);
    chk(nfr == 11, "R5 frame count", nfr, 11);
    ok = 1;
    for (int k = 0; k < 11; k++) if (f_op[k] != eop[k] || f_len[k] != eln[k]) ok = 0;
    chk(ok, "R5 R6 R9 frame order and lengths", f_op[5], 8'h09);
    ok = 1;
    for (int k = 0; k < 11; k++) if (k != 8 && f_mid[k] != 0) ok = 0;
    chk(ok, "R5 stuffing bytes zero", 0, 0);
    ok = (s_len == 13);
    for (int k = 0; k < 13; k++) if (s_b[k] != es[k]) ok = 0;
    chk(ok, "R8 load frame bytes", s_len, 13);
    ok = 1;
    for (int k = 5; k < 7; k++) if (f_fall[k+1] - f_rise[k] < WAITC) ok = 0;
    chk(ok, "R6 poll spacing", f_fall[6] - f_rise[5], WAITC);
    ok = 1;
    for (int k = 0; k < 10; k++) if (f_fall[k+1] - f_rise[k] < 2) ok = 0;
    chk(ok, "R2 chip-select gap", 0, 0);
    repeat (30) @(negedge clk);
    chk(cfg_done && spi_cs_n, "R10 done holds", cfg_done, 1);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!cfg_done && !cfg_err, "R10 start clears done", cfg_done, 0);
    repeat (2) @(negedge clk);
    bs_valid = 1'b1; bs_nodata = 1'b1; bs_last = 1'b1;
    #1; wait (cfg_done);
    @(negedge clk) bs_valid = 1'b0; bs_nodata = 1'b0; bs_last = 1'b0;
  endtask

  task automatic t_nodone();
    tx_n = 1; tx_d[0] = 8'h5A; use_gaps = 0; id_val = 32'hC204_8080; need = 0;
    fin_val = 32'hFFFF_BFFF;
    run_seq(0);
    chk(cfg_err && cfg_code == 2'd3, "R9 not done code", cfg_code, 3);
    chk(nfr == 9 && f_op[5] == 8'h09 && f_op[6] == 8'h41, "R6 single matching poll", nfr, 9);
    chk(s_len == 9 && s_b[4] == 8'h5A && s_b[5] == 8'h00 && s_b[8] == 8'h00,
        "R8 one-byte load frame", s_len, 9);
    chk(id_val == 32'hC204_8080 && f_op[1] == 8'h09, "R4 second ID accepted", f_op[1], 8'h09);
  endtask

  task automatic t_timeout();
    bit ok;
    tx_n = 2; tx_d[0] = 8'h01; tx_d[1] = 8'h02; use_gaps = 0; id_val = 32'hC208_8080;
    need = 99; fin_val = 32'h0000_4000;
    run_seq(0);
    chk(cfg_err && cfg_code == 2'd2, "R7 timeout code", cfg_code, 2);
    chk(nfr == 5 + LIM, "R7 poll count", nfr, 5 + LIM);
    ok = 1;
    for (int k = 5; k < 5 + LIM; k++) if (f_op[k] != 8'h09) ok = 0;
    chk(ok && s_len == 0, "R7 no load frame", s_len, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_empty();
    t_badid();
    t_good();
    t_nodone();
    t_timeout();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule